// File: doc/BRIEF.md
# Four-Wire Symbol Codec

This block converts between 5-bit symbol numbers and the 6-bit drive words that steer the six pairwise transmitters of a four-wire differential link. A four-wire link has 24 legal line states, so symbol numbers run from 0 to 23. A 6-bit word has 64 values, and only 24 of them give four wire currents that all differ. The encoder does not use a 24-entry lookup. It stores six 4-bit base patterns for X,Y,Z,U. It then makes the other three groups of six words from those patterns, using a one-place rotation, a bitwise complement, or both, chosen by the two low symbol bits.

The decoder performs the same steps in reverse. It undoes the complement and the rotation, then compares the result against the six base patterns. When no base pattern matches, it raises an error. This covers the 40 illegal words. The top module places both directions behind one register stage, so a transmit path and a receive path can share one instance.

Top module: `mwc4_codec`

## Requirements
- R1: Drive words are ordered {X,Y,Z,U,V,W} with X at bit 5. For a symbol s, V equals s[0] and W equals s[1]. s[4:2] selects a row of the base list. With X as the most significant bit, the base list is 0101, 1000, 1001, 1010, 1101, 1100 for rows 0 to 5.
- R2: When V,W = 00, X,Y,Z,U equals the base row. When V,W = 11, X,Y,Z,U equals the bitwise complement of the base row.
- R3: When V,W = 01, X,Y,Z,U is the base row rotated by one place, so that new X = old U, new Y = old X, new Z = old Y and new U = old Z. When V,W = 10, X,Y,Z,U is the complement of that rotated row.
- R4: A symbol number from 24 to 31 sets enc_err and gives the legal word 010100.
- R5: A drive word that is not one of the 24 words produced under R1 to R3 sets dec_err and gives sym_out = 0. Exactly 40 of the 64 words are illegal.
- R6: For every legal drive word, sym_out is the symbol number that encodes to that word. Encoding then decoding any symbol from 0 to 23 returns the original number.
- R7: Both directions take one clock cycle: the outputs hold the values for the inputs sampled at the previous rising edge. While rst_n is low, word_out is 010100 and sym_out, enc_err and dec_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_in | input | 5 | Symbol number to encode |
| word_in | input | 6 | Received drive word to decode |
| word_out | output | 6 | Encoded drive word {X,Y,Z,U,V,W} |
| enc_err | output | 1 | sym_in was above 23 |
| sym_out | output | 5 | Decoded symbol number |
| dec_err | output | 1 | word_in was an illegal drive word |

## Verification
The assertions make no assumption about the two inputs. Every 5-bit symbol and every 6-bit word is a valid stimulus: the top of the symbol range must produce an error flag, and so must illegal words. The only assumption is that the inputs are stable at the rising edge. The stimulus therefore covers both input spaces in full. It applies each of the 32 symbol numbers and each of the 64 drive words once, then adds random pairs that often fall in the illegal ranges. All inputs change on the falling edge.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int SYM_W   = 5;
  localparam int WORD_W  = 6;
  localparam int NIB_W   = WORD_W - 2;
  localparam int ROWS    = 6;
  localparam int GROUPS  = 4;
  localparam int LEGAL   = ROWS * GROUPS;
  localparam int IDX_W   = SYM_W - 2;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t SAFE_WORD = 6'b010100;

  // six shared X,Y,Z,U patterns, LSB alternating down the list
  function automatic nib_t base_row(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 4'b0101;
      3'd1:    return 4'b1000;
      3'd2:    return 4'b1001;
      3'd3:    return 4'b1010;
      3'd4:    return 4'b1101;
      3'd5:    return 4'b1100;
      default: return 4'b0101;
    endcase
  endfunction

  // X <- U, Y <- X, Z <- Y, U <- Z  (X is bit 3)
  function automatic nib_t rot_fwd(input nib_t n);
    return {n[0], n[3], n[2], n[1]};
  endfunction

  function automatic nib_t rot_back(input nib_t n);
    return {n[2], n[1], n[0], n[3]};
  endfunction
endpackage

// File: rtl/mwc_enc.sv
module mwc_enc
  import mwc_pkg::*;
(
  input  sym_t  sym,
  output word_t word,
  output logic  bad
);
  logic v_bit, w_bit;
  nib_t base, turned, shaped;

  assign v_bit  = sym[0];
  assign w_bit  = sym[1];
  assign bad    = (sym >= sym_t'(LEGAL));
  assign base   = base_row(sym[SYM_W-1:2]);
  assign turned = (v_bit ^ w_bit) ? rot_fwd(base) : base;
  assign shaped = v_bit ? ~turned : turned;
  assign word   = bad ? SAFE_WORD : {shaped, v_bit, w_bit};
endmodule

// File: rtl/mwc_dec.sv
module mwc_dec
  import mwc_pkg::*;
(
  input  word_t word,
  output sym_t  sym,
  output logic  bad
);
  logic v_bit, w_bit;
  nib_t flat, core;
  logic [ROWS-1:0]  hit;
  logic [IDX_W-1:0] idx;

  assign v_bit = word[1];
  assign w_bit = word[0];
  assign flat  = v_bit ? ~word[WORD_W-1:2] : word[WORD_W-1:2];
  assign core  = (v_bit ^ w_bit) ? rot_back(flat) : flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign hit[r] = (core == base_row(IDX_W'(r)));
  end

  always_comb begin
    idx = '0;
    for (int r = 0; r < ROWS; r++)
      if (hit[r]) idx = IDX_W'(r);
  end

  assign bad = ~|hit;
  assign sym = bad ? '0 : {idx, w_bit, v_bit};
endmodule

// File: rtl/mwc4_codec.sv
module mwc4_codec
  import mwc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  sym_in,
  input  logic [5:0]  word_in,
  output logic [5:0]  word_out,
  output logic        enc_err,
  output logic [4:0]  sym_out,
  output logic        dec_err
);
  word_t enc_word;
  logic  enc_bad;
  sym_t  dec_sym;
  logic  dec_bad;

  mwc_enc u_enc (.sym(sym_in), .word(enc_word), .bad(enc_bad));
  mwc_dec u_dec (.word(word_in), .sym(dec_sym), .bad(dec_bad));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out <= SAFE_WORD;
      enc_err  <= 1'b0;
      sym_out  <= '0;
      dec_err  <= 1'b0;
    end else begin
      word_out <= enc_word;
      enc_err  <= enc_bad;
      sym_out  <= dec_sym;
      dec_err  <= dec_bad;
    end
  end
endmodule

// File: rtl/mwc4_codec_chk.sv
module mwc4_codec_chk
  import mwc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sym_in,
  input logic [5:0] word_in,
  input logic [5:0] word_out,
  input logic       enc_err,
  input logic [4:0] sym_out,
  input logic       dec_err
);
  sym_t back_sym;
  logic back_bad;
  logic primed;

  mwc_dec u_back (.word(word_out), .sym(back_sym), .bad(back_bad));

  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_WORD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !back_bad); // R1

  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (enc_err == ($past(sym_in) >= 5'd24))); // R4

  AST_SAFE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err |-> (word_out == 6'b010100)); // R4

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !enc_err) |-> (back_sym == $past(sym_in))); // R6

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (sym_out == 5'd0)); // R5

  AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_err |-> (sym_out < 5'd24)); // R6

  AST_DEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(word_in)) |=> $stable(sym_out)); // R7
endmodule

bind mwc4_codec mwc4_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .word_in(word_in),
  .word_out(word_out), .enc_err(enc_err), .sym_out(sym_out), .dec_err(dec_err)
);

// File: tb/test_mwc4_codec.sv
module test_mwc4_codec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] sym_in;
  logic [5:0] word_in;
  logic [5:0] word_out;
  logic       enc_err;
  logic [4:0] sym_out;
  logic       dec_err;

  int n_chk = 0;
  int n_bad = 0;
  int illegal_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mwc4_codec i_mwc4_codec (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .word_in(word_in),
    .word_out(word_out), .enc_err(enc_err), .sym_out(sym_out), .dec_err(dec_err)
  );

  // base list written as one packed constant, row 0 in the low nibble
  function automatic logic [3:0] ref_base(input int row);
    logic [23:0] packed_rows = 24'hCDA985;
    return packed_rows[row*4 +: 4];
  endfunction

  // rotate by moving each bit one position toward lower significance
  function automatic logic [3:0] ref_rot(input logic [3:0] n);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = n[(k + 1) % 4];
    return r;
  endfunction

  function automatic logic [5:0] ref_word(input int s);
    logic [3:0] n;
    int row, v, w;
    if (s > 23) return 6'b010100;
    row = s / 4; v = s % 2; w = (s / 2) % 2;
    n = ref_base(row);
    if (v != w) n = ref_rot(n);
    if (v == 1) n = n ^ 4'hF;
    return {n, v[0], w[0]};
  endfunction

  function automatic int ref_sym(input logic [5:0] wd);
    for (int s = 0; s < 24; s++)
      if (ref_word(s) == wd) return s;
    return -1;
  endfunction

  function automatic string tag_enc(input int s);
    if (s > 23) return "R4";
    case (s % 4)
      0, 3:    return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int s, input logic [5:0] wd);
    int es;
    @(negedge clk);
    sym_in  = 5'(s);
    word_in = wd;
    @(negedge clk);
    check(tag_enc(s), "word_out", word_out, ref_word(s));
    check("R4", "enc_err", enc_err, (s > 23) ? 1 : 0);
    es = ref_sym(wd);
    check("R5", "dec_err", dec_err, (es < 0) ? 1 : 0);
    check("R6", "sym_out", sym_out, (es < 0) ? 0 : es);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    logic [5:0] prev;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; sym_in = 5'd27; word_in = 6'b111111;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", "reset word_out", word_out, 6'b010100);
    check("R7", "reset enc_err", enc_err, 0);
    check("R7", "reset sym_out", sym_out, 0);
    check("R7", "reset dec_err", dec_err, 0);
    rst_n = 1'b1;

    // R1 base row spot checks: symbol 8 -> row 2 = 1001, V=W=0
    apply(8, 6'b100100);
    check("R1", "sym 8 word", word_out, 6'b100100);
    apply(17, 6'b000000);
    check("R1", "sym 17 V,W", word_out[1:0], 2'b10);

    // R7 one-cycle latency: change input, see old value before the edge
    @(negedge clk);
    sym_in = 5'd0; word_in = 6'b010100;
    prev = word_out;
    @(posedge clk); #1;
    check("R7", "latency new word", word_out, ref_word(0));
    check("R7", "old word differs", (prev != word_out) ? 1 : 0, 1);

    for (int s = 0; s < 32; s++) apply(s, ref_word(s % 24));
    for (int w = 0; w < 64; w++) begin
      apply(w % 32, 6'(w));
      if (ref_sym(6'(w)) < 0) illegal_seen++;
    end
    check("R5", "illegal word count", illegal_seen, 40);

    // R6 round trip through the ports
    for (int s = 0; s < 24; s++) begin
      @(negedge clk);
      sym_in = 5'(s);
      @(negedge clk);
      word_in = word_out;
      @(negedge clk);
      check("R6", "round trip", sym_out, s);
    end

    for (int k = 0; k < 400; k++) apply(int'($urandom_range(0, 31)), 6'($urandom_range(0, 63)));

    finish_run();
  end
endmodule